// File: doc/BRIEF.md
# Multicycle Control Step Sequencer

This block is the control unit of a processor that runs every instruction in five timing steps. A one-hot step counter walks through T1 to T5 and then wraps to T1. Step T1 is the instruction fetch. It is the same for every instruction and waits for the memory completion handshake before it moves on. Step T4 of a load or a store also waits for that handshake. In every other step the counter advances on each clock.

The class of the instruction is decoded outside the block from the instruction register and arrives as a 3-bit code. From that code, the current step, the handshake and the branch-condition flag, the block forms each control output as a sum of products of step terms and class terms. The outputs are the PC load enable and its source select, the instruction register load, the register-file write enable with its destination and data selects, and the memory read and write commands. The ALU, the register file and the memory sit outside the block.

Top module: `mc_step_ctrl`

## Requirements
- R1: While `rst_n` is low, `step_o` shows T1 (`5'b00001`) from the first clock edge on, and every enable, command and select output is 0, whatever the other inputs are.
- R2: `step_o` is one-hot, with bit k meaning step T(k+1). It advances by one step per clock except during a stall, and T5 is followed by T1.
- R3: In T1, `mem_rd_o` is 1 on every cycle. The counter holds in T1 until `mfc_i` is 1. `ir_en_o` and `pc_en_o` (with `pc_sel_o`=0, increment) are 1 only in the T1 cycle where `mfc_i` is 1.
- R4: Class codes are ALU=0, LOAD=1, STORE=2, BRANCH=3, CBRANCH=4, CALL=5, RETURN=6, JUMP=7. In T4, a LOAD asserts `mem_rd_o` and a STORE asserts `mem_wr_o`. The command stays high and the counter holds until `mfc_i` is 1. The command drops as the counter moves to T5.
- R5: In T3, `pc_en_o` is 1 for BRANCH, JUMP, CALL and RETURN, and for CBRANCH only when `br_taken_i` is 1. `pc_sel_o` is 1 (offset target) for BRANCH, CBRANCH and CALL, and 2 (register target) for RETURN and JUMP. Otherwise `pc_sel_o` is 0.
- R6: `rf_we_o` is 1 only in T5, and only for ALU, LOAD and CALL. `ry_sel_o` is 0 for ALU data, 1 for memory data and 2 for the saved return address. `rf_link_o` is 1 only for CALL. Both selects are 0 whenever `rf_we_o` is 0.
- R7: For BRANCH, CBRANCH, RETURN, JUMP and STORE, T5 asserts no memory command and no register write. The branch-type classes also assert none in T4.
- R8: `mfc_i` has no effect in T2, T3 and T5, nor in T4 for classes other than LOAD and STORE. The step still advances and no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| iclass_i | input | 3 | Decoded instruction class code |
| mfc_i | input | 1 | Memory function complete handshake |
| br_taken_i | input | 1 | Branch condition met |
| step_o | output | 5 | One-hot current step |
| pc_en_o | output | 1 | PC load enable |
| pc_sel_o | output | 2 | PC source: 0 increment, 1 offset, 2 register |
| ir_en_o | output | 1 | Instruction register load |
| rf_we_o | output | 1 | Register-file write enable |
| rf_link_o | output | 1 | Write destination is the link register |
| ry_sel_o | output | 2 | Write data: 0 ALU, 1 memory, 2 return address |
| mem_rd_o | output | 1 | Memory read command |
| mem_wr_o | output | 1 | Memory write command |

## Verification
The assertions assume that `iclass_i` and `br_taken_i` stay constant from T2 through T5 of one instruction, the way a held instruction register would keep them. A memory command that is waiting must stay up until `mfc_i` arrives, and that only holds when the class does not change. The driver sets the class once for each whole instruction. It raises `mfc_i` only after a chosen number of wait cycles in T1 and in the T4 of loads and stores, and on some runs it also raises `mfc_i` in the steps that must ignore it. The bench then compares every output on every cycle.

// File: rtl/mc_step_pkg.sv
package mc_step_pkg;

    localparam int NUM_STEPS   = 5;
    localparam int STEP_FETCH  = 0;
    localparam int STEP_DECODE = 1;
    localparam int STEP_EXEC   = 2;
    localparam int STEP_MEM    = 3;
    localparam int STEP_WB     = 4;
    localparam int CLS_W       = 3;
    localparam int NUM_CLS     = 1 << CLS_W;

    typedef enum logic [CLS_W-1:0] {
        CLS_ALU    = 3'd0,
        CLS_LOAD   = 3'd1,
        CLS_STORE  = 3'd2,
        CLS_BRANCH = 3'd3,
        CLS_CBR    = 3'd4,
        CLS_CALL   = 3'd5,
        CLS_RETURN = 3'd6,
        CLS_JUMP   = 3'd7
    } iclass_e;

    typedef enum logic [1:0] {
        PCS_INC = 2'd0,
        PCS_OFF = 2'd1,
        PCS_REG = 2'd2
    } pc_sel_e;

    typedef enum logic [1:0] {
        RYS_ALU  = 2'd0,
        RYS_MEM  = 2'd1,
        RYS_LINK = 2'd2
    } ry_sel_e;

    typedef struct packed {
        logic is_alu;
        logic is_load;
        logic is_store;
        logic is_br;
        logic is_cbr;
        logic is_call;
        logic is_ret;
        logic is_jmp;
    } cls_flags_t;

    typedef struct packed {
        logic    pc_en;
        pc_sel_e pc_sel;
        logic    ir_en;
        logic    rf_we;
        logic    rf_link;
        ry_sel_e ry_sel;
        logic    mem_rd;
        logic    mem_wr;
    } ctrl_t;

endpackage

// File: rtl/mc_step_counter.sv
module mc_step_counter #(
    parameter int NUM = mc_step_pkg::NUM_STEPS
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hold_i,
    output logic [NUM-1:0] step_o
);

    typedef struct packed {
        logic [NUM-1:0] step;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!hold_i) begin
            cnt_d.step = {cnt_q.step[NUM-2:0], cnt_q.step[NUM-1]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q.step <= NUM'(1);
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign step_o = cnt_q.step;

    // R2: exactly one step active
    p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(step_o) == 1);

    // R2: last step wraps to the first
    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o[NUM-1] && !hold_i) |=> step_o[0]);

    // R3 / R4: a stall keeps the step
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> $stable(step_o));

endmodule

// File: rtl/mc_class_dec.sv
module mc_class_dec
    import mc_step_pkg::*;
(
    input  logic [CLS_W-1:0] code_i,
    output cls_flags_t       flags_o
);

    logic [NUM_CLS-1:0] hot;

    always_comb begin
        hot = '0;
        hot[code_i] = 1'b1;
    end

    assign flags_o.is_alu   = hot[CLS_ALU];
    assign flags_o.is_load  = hot[CLS_LOAD];
    assign flags_o.is_store = hot[CLS_STORE];
    assign flags_o.is_br    = hot[CLS_BRANCH];
    assign flags_o.is_cbr   = hot[CLS_CBR];
    assign flags_o.is_call  = hot[CLS_CALL];
    assign flags_o.is_ret   = hot[CLS_RETURN];
    assign flags_o.is_jmp   = hot[CLS_JUMP];

endmodule

// File: rtl/mc_enable_gen.sv
module mc_enable_gen
    import mc_step_pkg::*;
(
    input  logic                 rst_n,
    input  logic [NUM_STEPS-1:0] step_i,
    input  cls_flags_t           cls_i,
    input  logic                 mfc_i,
    input  logic                 taken_i,
    output logic                 hold_o,
    output ctrl_t                ctrl_o
);

    logic t_f, t_e, t_m, t_w;
    logic mem_op, redirect, wb_class;

    assign t_f = step_i[STEP_FETCH];
    assign t_e = step_i[STEP_EXEC];
    assign t_m = step_i[STEP_MEM];
    assign t_w = step_i[STEP_WB];

    assign mem_op   = cls_i.is_load | cls_i.is_store;
    assign redirect = cls_i.is_br | cls_i.is_jmp | cls_i.is_call | cls_i.is_ret
                    | (cls_i.is_cbr & taken_i);
    assign wb_class = cls_i.is_alu | cls_i.is_load | cls_i.is_call;

    // wait for the handshake in fetch and in the data access of loads/stores
    assign hold_o = (t_f & ~mfc_i) | (t_m & mem_op & ~mfc_i);

    always_comb begin
        ctrl_o = '0;
        if (rst_n) begin
            ctrl_o.pc_en   = (t_f & mfc_i) | (t_e & redirect);
            ctrl_o.ir_en   = t_f & mfc_i;
            ctrl_o.mem_rd  = t_f | (t_m & cls_i.is_load);
            ctrl_o.mem_wr  = t_m & cls_i.is_store;
            ctrl_o.rf_we   = t_w & wb_class;
            ctrl_o.rf_link = t_w & cls_i.is_call;
            if (t_e & redirect) begin
                ctrl_o.pc_sel = (cls_i.is_ret | cls_i.is_jmp) ? PCS_REG : PCS_OFF;
            end
            if (t_w & cls_i.is_load) begin
                ctrl_o.ry_sel = RYS_MEM;
            end else if (t_w & cls_i.is_call) begin
                ctrl_o.ry_sel = RYS_LINK;
            end
        end
    end

endmodule

// File: rtl/mc_step_ctrl.sv
module mc_step_ctrl
    import mc_step_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CLS_W-1:0]     iclass_i,
    input  logic                 mfc_i,
    input  logic                 br_taken_i,
    output logic [NUM_STEPS-1:0] step_o,
    output logic                 pc_en_o,
    output logic [1:0]           pc_sel_o,
    output logic                 ir_en_o,
    output logic                 rf_we_o,
    output logic                 rf_link_o,
    output logic [1:0]           ry_sel_o,
    output logic                 mem_rd_o,
    output logic                 mem_wr_o
);

    logic       hold;
    cls_flags_t flags;
    ctrl_t      ctrl;

    mc_step_counter #(.NUM(NUM_STEPS)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold_i (hold),
        .step_o (step_o)
    );

    mc_class_dec u_dec (
        .code_i  (iclass_i),
        .flags_o (flags)
    );

    mc_enable_gen u_en (
        .rst_n   (rst_n),
        .step_i  (step_o),
        .cls_i   (flags),
        .mfc_i   (mfc_i),
        .taken_i (br_taken_i),
        .hold_o  (hold),
        .ctrl_o  (ctrl)
    );

    assign pc_en_o   = ctrl.pc_en;
    assign pc_sel_o  = ctrl.pc_sel;
    assign ir_en_o   = ctrl.ir_en;
    assign rf_we_o   = ctrl.rf_we;
    assign rf_link_o = ctrl.rf_link;
    assign ry_sel_o  = ctrl.ry_sel;
    assign mem_rd_o  = ctrl.mem_rd;
    assign mem_wr_o  = ctrl.mem_wr;

    // R3: fetch keeps reading while waiting
    p_fetch_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o[STEP_FETCH] && !mfc_i) |=> (step_o[STEP_FETCH] && mem_rd_o));

    // R3: instruction load is followed by decode
    p_ir_then_decode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ir_en_o |=> step_o[STEP_DECODE]);

    // R4: a pending write stays up until completion
    p_wr_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_o && !mfc_i) |=> mem_wr_o);

    // R5: a non-fetch PC load only happens in the execute step
    p_pc_exec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_en_o && !step_o[STEP_FETCH]) |-> step_o[STEP_EXEC]);

    // R6: a register write is followed by the next fetch
    p_we_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o |=> step_o[STEP_FETCH]);

    // R7: never read and write memory together
    p_mem_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_o && mem_wr_o));

endmodule

// File: tb/mc_step_ctrl_tb_top.sv
module mc_step_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] iclass = 3'd0;
    logic       mfc = 1'b0;
    logic       taken = 1'b0;
    logic [4:0] step;
    logic       pc_en, ir_en, rf_we, rf_link, mem_rd, mem_wr;
    logic [1:0] pc_sel, ry_sel;

    always #5 clk = ~clk;

    mc_step_ctrl dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .iclass_i   (iclass),
        .mfc_i      (mfc),
        .br_taken_i (taken),
        .step_o     (step),
        .pc_en_o    (pc_en),
        .pc_sel_o   (pc_sel),
        .ir_en_o    (ir_en),
        .rf_we_o    (rf_we),
        .rf_link_o  (rf_link),
        .ry_sel_o   (ry_sel),
        .mem_rd_o   (mem_rd),
        .mem_wr_o   (mem_wr)
    );

    typedef struct {
        int   req;
        logic [4:0] step;
        logic pc_en;
        logic [1:0] pc_sel;
        logic ir_en;
        logic rf_we;
        logic rf_link;
        logic [1:0] ry_sel;
        logic mem_rd;
        logic mem_wr;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int errors = 0;
    int bstep = 0;

    task automatic chk(input int req, input string nm, input int act, input int expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL R%0d %s actual=%0h expected=%0h", req, nm, act, expv);
        end
    endtask

    // monitor: compare each cycle away from the clock edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                chk(e.req, "step",    int'(step),    int'(e.step));
                chk(e.req, "pc_en",   int'(pc_en),   int'(e.pc_en));
                chk(e.req, "pc_sel",  int'(pc_sel),  int'(e.pc_sel));
                chk(e.req, "ir_en",   int'(ir_en),   int'(e.ir_en));
                chk(e.req, "rf_we",   int'(rf_we),   int'(e.rf_we));
                chk(e.req, "rf_link", int'(rf_link), int'(e.rf_link));
                chk(e.req, "ry_sel",  int'(ry_sel),  int'(e.ry_sel));
                chk(e.req, "mem_rd",  int'(mem_rd),  int'(e.mem_rd));
                chk(e.req, "mem_wr",  int'(mem_wr),  int'(e.mem_wr));
            end
        end
    end

    // driver: one cycle of stimulus plus its expected outputs
    task automatic cyc(input logic [2:0] cls, input logic tk, input logic m);
        exp_t e;
        bit ld, st, flow, stall;
        @(negedge clk);
        iclass = cls;
        taken  = tk;
        mfc    = m;
        ld   = (cls == 3'd1);
        st   = (cls == 3'd2);
        flow = (cls == 3'd3) || (cls == 3'd5) || (cls == 3'd6) || (cls == 3'd7)
             || ((cls == 3'd4) && tk);
        e.step    = 5'(1 << bstep);
        e.pc_en   = ((bstep == 0) && m) || ((bstep == 2) && flow);
        e.pc_sel  = ((bstep == 2) && flow) ? (((cls == 3'd6) || (cls == 3'd7)) ? 2'd2 : 2'd1) : 2'd0;
        e.ir_en   = (bstep == 0) && m;
        e.mem_rd  = (bstep == 0) || ((bstep == 3) && ld);
        e.mem_wr  = (bstep == 3) && st;
        e.rf_we   = (bstep == 4) && ((cls == 3'd0) || ld || (cls == 3'd5));
        e.rf_link = (bstep == 4) && (cls == 3'd5);
        e.ry_sel  = (bstep == 4) ? (ld ? 2'd1 : ((cls == 3'd5) ? 2'd2 : 2'd0)) : 2'd0;
        // tag: R3 fetch, R4 data access, R5 execute, R6 write-back,
        // R7 idle T4/T5 of flow/store, R8 ignored handshake, R2 otherwise
        if (bstep == 0)                                   e.req = 3;
        else if ((bstep == 3) && (ld || st))              e.req = 4;
        else if (m && ((bstep == 1) || (bstep == 2) || (bstep == 3) || (bstep == 4))) e.req = 8;
        else if (bstep == 2)                              e.req = 5;
        else if ((bstep >= 3) && (e.rf_we == 1'b0) && !ld && (cls != 3'd0)) e.req = 7;
        else if (bstep == 4)                              e.req = 6;
        else                                              e.req = 2;
        exp_q.push_back(e);
        stall = ((bstep == 0) && !m) || ((bstep == 3) && (ld || st) && !m);
        if (!stall) bstep = (bstep + 1) % 5;
    endtask

    task automatic run_instr(input logic [2:0] cls, input logic tk,
                             input int fwait, input int mwait, input logic noise);
        for (int i = 0; i < fwait; i++) cyc(cls, tk, 1'b0);
        cyc(cls, tk, 1'b1);                // T1 completes
        cyc(cls, tk, noise);               // T2
        cyc(cls, tk, noise);               // T3
        if ((cls == 3'd1) || (cls == 3'd2)) begin
            for (int i = 0; i < mwait; i++) cyc(cls, tk, 1'b0);
            cyc(cls, tk, 1'b1);            // T4 completes
        end else begin
            cyc(cls, tk, noise);           // T4, handshake ignored
        end
        cyc(cls, tk, noise);               // T5
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset forces T1 and silences outputs despite active inputs
        repeat (2) @(negedge clk);
        begin
            exp_t r;
            iclass = 3'd1;
            mfc = 1'b1;
            taken = 1'b1;
            r = '{req: 1, step: 5'b00001, pc_en: 1'b0, pc_sel: 2'd0, ir_en: 1'b0,
                  rf_we: 1'b0, rf_link: 1'b0, ry_sel: 2'd0, mem_rd: 1'b0, mem_wr: 1'b0};
            exp_q.push_back(r);
        end
        @(negedge clk);
        rst_n = 1'b1;
        mfc = 1'b0;
        bstep = 0;

        // R2..R6: every class, no wait states, quiet handshake
        for (int c = 0; c < 8; c++) run_instr(3'(c), 1'b1, 0, 0, 1'b0);
        // R5: conditional branch not taken
        run_instr(3'd4, 1'b0, 0, 0, 1'b0);
        // R3/R4/R8: wait states and handshake noise in other steps
        for (int c = 0; c < 8; c++) run_instr(3'(c), 1'b0, 2, 3, 1'b1);
        // R4: long waits on load then store back to back
        run_instr(3'd1, 1'b0, 1, 5, 1'b0);
        run_instr(3'd2, 1'b0, 3, 1, 1'b1);
        // R7: flow-change classes with noise
        run_instr(3'd6, 1'b1, 0, 0, 1'b1);
        run_instr(3'd4, 1'b1, 1, 0, 1'b1);

        @(negedge clk);
        #3;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule